// File: doc/BRIEF.md
# Event-Driven Power Mode Controller

This block keeps track of which of seven operating modes a small processor core is in, and drives the clock enables that follow from that mode. The seven modes are one Sleep mode, three run modes and three idle modes. A run mode clocks both the CPU and the peripherals. An idle mode stops the CPU clock but keeps the peripheral clock running. Sleep stops every clock. Each run mode and each idle mode is tied to one of three clock sources: primary, secondary or internal oscillator.

Software sets an idle-enable bit and a 2-bit clock-select field through a write port. When the core issues its sleep instruction, the block reads both values as they stand. It then enters Sleep, or the idle mode for the selected source. While the core runs, writing a new clock-select value moves it straight to the run mode for that source. Any wake event returns the core to primary run and clears the clock-select field. The wake events are an interrupt, a soft reset or a watchdog time-out, given as a parameterised vector. The oscillators, the glitch-free clock multiplexers and the start-up timers lie outside this block. The block only produces the selection and the enables.

Top module: `power_mode_ctrl`

## Requirements
- R1: After the asynchronous reset, `mode_code` is 3'b001 (primary run), `idle_en_q` is 0, `clk_sel_q` is 2'b00, both clock enables are 1 and `clk_src` is 2'b01.
- R2: Mode codes are: bit 2 set for idle, bits 1:0 the source, with source 2'b01 primary, 2'b10 secondary, 2'b11 internal; Sleep is 3'b000. `clk_src` equals bits 1:0 of the mode code (2'b00 = none). In Sleep both enables are 0; in idle `cpu_clk_en` is 0 and `per_clk_en` is 1; in run both are 1.
- R3: A sleep strobe in any run mode with `idle_en_q` = 0 gives Sleep (3'b000) at the next clock edge, whatever `clk_sel_q` holds.
- R4: A sleep strobe in a run mode with `idle_en_q` = 1 gives the idle mode for the current clock-select field: 2'b00 gives 3'b101, 2'b01 gives 3'b110, and 2'b1x gives 3'b111.
- R5: A register write in a run mode, with no sleep strobe and no wake event, moves the mode at the next edge to the run mode for the written clock-select value: 2'b00 gives 3'b001, 2'b01 gives 3'b010, and 2'b1x gives 3'b011 (bit 0 is ignored).
- R6: A register write while in Sleep or an idle mode updates `idle_en_q` and `clk_sel_q` but leaves `mode_code` unchanged.
- R7: Any single bit of `wake_evt` (bit 0 interrupt, bit 1 soft reset, bit 2 watchdog) gives 3'b001 at the next edge from any mode. It clears `clk_sel_q` to 2'b00 and keeps `idle_en_q`.
- R8: A wake event takes priority over a sleep strobe and a register write in the same cycle: the mode becomes 3'b001, `clk_sel_q` becomes 2'b00, and the write is discarded.
- R9: A sleep strobe in Sleep or in an idle mode has no effect on the mode.
- R10: When a sleep strobe and a register write arrive together in a run mode, the destination comes from the register values held before the write. The write still lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_evt | input | NUM_WAKE | Wake events: bit 0 interrupt, bit 1 soft reset, bit 2 watchdog |
| sleep_stb | input | 1 | One-cycle strobe from the sleep instruction |
| cfg_we | input | 1 | Write strobe for the control bits |
| cfg_idle_en | input | 1 | Idle-enable value to write |
| cfg_clk_sel | input | CSEL_W | Clock-select value to write |
| mode_code | output | CSEL_W+1 | Registered current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| clk_src | output | CSEL_W | Selected clock source (00 none) |
| idle_en_q | output | 1 | Stored idle-enable bit |
| clk_sel_q | output | CSEL_W | Stored clock-select field |

## Verification
Every result is due exactly one clock edge after the cycle in which its stimulus is held. This covers the new mode code, the stored control bits, and the enables and source decoded from that mode. The driver applies one stimulus per cycle on the falling edge. It queues the expected state for that cycle. The monitor takes each entry off the queue 5 ns after the next rising edge, so every comparison sees the state that this edge produced and nothing later.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam logic [1:0] SRC_NONE = 2'b00;
   localparam logic [1:0] SRC_PRI  = 2'b01;
   localparam logic [1:0] SRC_SEC  = 2'b10;
   localparam logic [1:0] SRC_INT  = 2'b11;

   localparam logic [2:0] PM_SLEEP    = 3'b000;
   localparam logic [2:0] PM_RUN_PRI  = 3'b001;
   localparam logic [2:0] PM_RUN_SEC  = 3'b010;
   localparam logic [2:0] PM_RUN_INT  = 3'b011;
   localparam logic [2:0] PM_IDLE_PRI = 3'b101;
   localparam logic [2:0] PM_IDLE_SEC = 3'b110;
   localparam logic [2:0] PM_IDLE_INT = 3'b111;

   // select field -> source code; the low bit is irrelevant once bit 1 is set
   function automatic logic [1:0] csel_to_src(input logic [1:0] csel);
      if (csel[1])      return SRC_INT;
      else if (csel[0]) return SRC_SEC;
      else              return SRC_PRI;
   endfunction

   function automatic logic is_run(input logic [2:0] mode);
      return (mode[1:0] != SRC_NONE) && !mode[2];
   endfunction

   function automatic logic is_clocked(input logic [2:0] mode);
      return mode[1:0] != SRC_NONE;
   endfunction
endpackage

// File: rtl/pmc_ctrl_regs.sv
module pmc_ctrl_regs #(
   parameter int CSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wake_any,
   input  logic              wr_en,
   input  logic              wr_idle,
   input  logic [CSEL_W-1:0] wr_csel,
   output logic              idle_q,
   output logic [CSEL_W-1:0] csel_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q <= 1'b0;
         csel_q <= '0;
      end else if (wake_any) begin
         // wake returns the register state to primary run; pending write dropped
         csel_q <= '0;
      end else if (wr_en) begin
         idle_q <= wr_idle;
         csel_q <= wr_csel;
      end
   end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
   import pmc_pkg::*;
#(
   parameter int CSEL_W = 2,
   localparam int MODE_W = CSEL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wake_any,
   input  logic              sleep_stb,
   input  logic              wr_en,
   input  logic [CSEL_W-1:0] wr_csel,
   input  logic              idle_q,
   input  logic [CSEL_W-1:0] csel_q,
   output logic [MODE_W-1:0] mode_q
);
   logic [MODE_W-1:0] mode_d;

   always_comb begin
      mode_d = mode_q;
      if (wake_any) begin
         mode_d = PM_RUN_PRI;
      end else if (is_run(mode_q)) begin
         if (sleep_stb)
            mode_d = idle_q ? {1'b1, csel_to_src(csel_q)} : PM_SLEEP;
         else if (wr_en)
            mode_d = {1'b0, csel_to_src(wr_csel)};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= PM_RUN_PRI;
      else        mode_q <= mode_d;
   end
endmodule

// File: rtl/pmc_clk_decode.sv
module pmc_clk_decode
   import pmc_pkg::*;
#(
   parameter int CSEL_W = 2,
   localparam int MODE_W = CSEL_W + 1
) (
   input  logic [MODE_W-1:0] mode,
   output logic              cpu_en,
   output logic              per_en,
   output logic [CSEL_W-1:0] src
);
   always_comb begin
      cpu_en = is_run(mode);
      per_en = is_clocked(mode);
      src    = mode[CSEL_W-1:0];
   end
endmodule

// File: rtl/power_mode_ctrl.sv
module power_mode_ctrl #(
   parameter int                  NUM_WAKE = 3,
   parameter int                  CSEL_W   = 2,
   parameter logic [NUM_WAKE-1:0] WAKE_EN  = '1,
   localparam int                 MODE_W   = CSEL_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_WAKE-1:0] wake_evt,
   input  logic                sleep_stb,
   input  logic                cfg_we,
   input  logic                cfg_idle_en,
   input  logic [CSEL_W-1:0]   cfg_clk_sel,
   output logic [MODE_W-1:0]   mode_code,
   output logic                cpu_clk_en,
   output logic                per_clk_en,
   output logic [CSEL_W-1:0]   clk_src,
   output logic                idle_en_q,
   output logic [CSEL_W-1:0]   clk_sel_q
);
   if (CSEL_W != 2) begin : g_bad_csel
      $error("power_mode_ctrl: CSEL_W must be 2");
   end
   if (NUM_WAKE < 1) begin : g_bad_wake
      $error("power_mode_ctrl: NUM_WAKE must be at least 1");
   end

   logic [NUM_WAKE-1:0] wake_hit;
   logic                wake_any;

   for (genvar i = 0; i < NUM_WAKE; i++) begin : g_wake
      assign wake_hit[i] = wake_evt[i] & WAKE_EN[i];
   end
   assign wake_any = |wake_hit;

   pmc_ctrl_regs #(.CSEL_W(CSEL_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wake_any (wake_any),
      .wr_en    (cfg_we),
      .wr_idle  (cfg_idle_en),
      .wr_csel  (cfg_clk_sel),
      .idle_q   (idle_en_q),
      .csel_q   (clk_sel_q)
   );

   pmc_mode_fsm #(.CSEL_W(CSEL_W)) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wake_any  (wake_any),
      .sleep_stb (sleep_stb),
      .wr_en     (cfg_we),
      .wr_csel   (cfg_clk_sel),
      .idle_q    (idle_en_q),
      .csel_q    (clk_sel_q),
      .mode_q    (mode_code)
   );

   pmc_clk_decode #(.CSEL_W(CSEL_W)) dec_i (
      .mode   (mode_code),
      .cpu_en (cpu_clk_en),
      .per_en (per_clk_en),
      .src    (clk_src)
   );
endmodule

// File: rtl/power_mode_ctrl_chk.sv
module power_mode_ctrl_chk #(
   parameter int NUM_WAKE = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_WAKE-1:0] wake_evt,
   input logic                sleep_stb,
   input logic                cfg_we,
   input logic [1:0]          cfg_clk_sel,
   input logic [2:0]          mode_code,
   input logic                cpu_clk_en,
   input logic                per_clk_en,
   input logic [1:0]          clk_src,
   input logic                idle_en_q,
   input logic [1:0]          clk_sel_q
);
   logic       woke, in_run;
   logic [1:0] held_src, wr_src;

   assign woke     = |wake_evt;
   assign in_run   = (mode_code[1:0] != 2'b00) && !mode_code[2];
   assign held_src = pmc_pkg::csel_to_src(clk_sel_q);
   assign wr_src   = pmc_pkg::csel_to_src(cfg_clk_sel);

   // R2
   a_r2_sleep_no_clocks: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'b000) |-> (!cpu_clk_en && !per_clk_en && clk_src == 2'b00));
   a_r2_idle_cpu_off: assert property (@(posedge clk) disable iff (!rst_n)
      mode_code[2] |-> (!cpu_clk_en && per_clk_en));
   // R7
   a_r7_wake_to_pri: assert property (@(posedge clk) disable iff (!rst_n)
      woke |=> (mode_code == 3'b001 && clk_sel_q == 2'b00));
   // R3
   a_r3_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (!woke && sleep_stb && in_run && !idle_en_q) |=> (mode_code == 3'b000));
   // R4, R10
   a_r4_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (!woke && sleep_stb && in_run && idle_en_q) |=>
         (mode_code[2] && mode_code[1:0] == $past(held_src)));
   // R5
   a_r5_follow_csel: assert property (@(posedge clk) disable iff (!rst_n)
      (!woke && !sleep_stb && in_run && cfg_we) |=>
         (mode_code == {1'b0, $past(wr_src)}));
   // R6, R9
   a_r9_parked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!woke && !in_run) |=> $stable(mode_code));
endmodule

bind power_mode_ctrl power_mode_ctrl_chk #(.NUM_WAKE(NUM_WAKE)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .wake_evt    (wake_hit),
   .sleep_stb   (sleep_stb),
   .cfg_we      (cfg_we),
   .cfg_clk_sel (cfg_clk_sel),
   .mode_code   (mode_code),
   .cpu_clk_en  (cpu_clk_en),
   .per_clk_en  (per_clk_en),
   .clk_src     (clk_src),
   .idle_en_q   (idle_en_q),
   .clk_sel_q   (clk_sel_q)
);

// File: tb/power_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module power_mode_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] wake_evt = '0;
   logic       sleep_stb = 1'b0, cfg_we = 1'b0, cfg_idle_en = 1'b0;
   logic [1:0] cfg_clk_sel = '0;
   logic [2:0] mode_code;
   logic       cpu_clk_en, per_clk_en, idle_en_q;
   logic [1:0] clk_src, clk_sel_q;

   always #10 clk = ~clk;

   power_mode_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .sleep_stb(sleep_stb),
      .cfg_we(cfg_we), .cfg_idle_en(cfg_idle_en), .cfg_clk_sel(cfg_clk_sel),
      .mode_code(mode_code), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
      .clk_src(clk_src), .idle_en_q(idle_en_q), .clk_sel_q(clk_sel_q)
   );

   typedef struct {
      logic [2:0] mode;
      logic       idle;
      logic [1:0] csel;
      string      tag;
   } exp_t;

   exp_t       sb_q[$];
   int         n_cmp = 0, n_bad = 0;
   bit         done = 0;
   logic [2:0] m_mode = 3'b001;
   logic       m_idle = 1'b0;
   logic [1:0] m_csel = 2'b00;

   function automatic logic [1:0] src_of(input logic [1:0] c);
      return c[1] ? 2'b11 : (c[0] ? 2'b10 : 2'b01);
   endfunction

   task automatic compare(input exp_t e);
      logic       e_cpu, e_per, run;
      logic [1:0] e_src;
      run   = (e.mode == 3'b001 || e.mode == 3'b010 || e.mode == 3'b011);
      e_cpu = run;                       // R2
      e_per = (e.mode != 3'b000);
      e_src = e.mode[1:0];
      n_cmp++;
      if (mode_code !== e.mode || idle_en_q !== e.idle || clk_sel_q !== e.csel ||
          cpu_clk_en !== e_cpu || per_clk_en !== e_per || clk_src !== e_src) begin
         n_bad++;
         $display("FAIL %s: mode/idle/csel/cpu/per/src actual %b/%b/%b/%b/%b/%b expected %b/%b/%b/%b/%b/%b",
                  e.tag, mode_code, idle_en_q, clk_sel_q, cpu_clk_en, per_clk_en, clk_src,
                  e.mode, e.idle, e.csel, e_cpu, e_per, e_src);
      end
   endtask

   // driver: one stimulus per cycle, expected state pushed to the scoreboard
   task automatic step(input logic [2:0] wk, input logic slp, input logic we,
                       input logic widle, input logic [1:0] wcs, input string tag);
      logic run;
      exp_t e;
      @(negedge clk);
      wake_evt = wk; sleep_stb = slp; cfg_we = we;
      cfg_idle_en = widle; cfg_clk_sel = wcs;
      if (wk != 3'b000) begin
         m_mode = 3'b001;
         m_csel = 2'b00;
      end else begin
         run = (m_mode == 3'b001 || m_mode == 3'b010 || m_mode == 3'b011);
         if (run && slp)     m_mode = m_idle ? {1'b1, src_of(m_csel)} : 3'b000;
         else if (run && we) m_mode = {1'b0, src_of(wcs)};
         if (we) begin
            m_idle = widle;
            m_csel = wcs;
         end
      end
      e.mode = m_mode; e.idle = m_idle; e.csel = m_csel; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // monitor: sample 5 ns after the edge that produced the result
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb_q.size() > 0) compare(sb_q.pop_front());
      end
   end

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      exp_t r;
      #35;
      r.mode = 3'b001; r.idle = 1'b0; r.csel = 2'b00; r.tag = "R1 reset";
      compare(r);
      rst_n = 1'b1;
      step(3'b000, 0, 0, 0, 2'b00, "R1 hold");
      step(3'b000, 1, 0, 0, 2'b00, "R3 pri run to sleep");
      step(3'b000, 1, 0, 0, 2'b00, "R9 strobe in sleep");
      step(3'b000, 0, 1, 1, 2'b01, "R6 write in sleep");
      step(3'b001, 0, 0, 0, 2'b00, "R7 interrupt wake");
      step(3'b000, 1, 0, 0, 2'b00, "R4 pri idle");
      step(3'b000, 1, 0, 0, 2'b00, "R9 strobe in idle");
      step(3'b100, 0, 0, 0, 2'b00, "R7 watchdog wake");
      step(3'b000, 0, 1, 1, 2'b01, "R5 to sec run");
      step(3'b000, 1, 0, 0, 2'b00, "R4 sec idle");
      step(3'b000, 0, 1, 1, 2'b10, "R6 write in idle");
      step(3'b010, 0, 0, 0, 2'b00, "R7 soft reset wake");
      step(3'b000, 0, 1, 1, 2'b11, "R5 to int run");
      step(3'b000, 0, 1, 0, 2'b10, "R5 low bit ignored");
      step(3'b000, 1, 0, 0, 2'b00, "R3 int run to sleep");
      step(3'b000, 0, 1, 1, 2'b10, "R6 write in sleep");
      step(3'b001, 1, 1, 0, 2'b01, "R8 wake beats sleep and write");
      step(3'b000, 0, 1, 1, 2'b10, "R5 to int run again");
      step(3'b000, 1, 0, 0, 2'b00, "R4 int idle");
      step(3'b100, 0, 0, 0, 2'b00, "R7 wake from idle");
      step(3'b000, 1, 1, 0, 2'b01, "R10 sleep with write uses old values");
      step(3'b000, 0, 0, 0, 2'b00, "R10 settle");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule